// File: doc/BRIEF.md
# Block-Cipher Accelerator Register Front-End

This block is the software-facing register file of a block-cipher engine. A simple 32-bit peripheral bus (byte address, write strobe, read strobe, write data, combinational read data) reaches a control word, a mode word and interrupt enable, disable, mask and status words. It also reaches four-word banks for the key, the input block, the result block and the chaining vector, plus a read-only version word. The block decides when the engine starts: on an explicit command, once the whole input block is filled, or on the write of input word 0. In that last mode an optional double-buffer setting lets the next block be loaded while the current one runs.

Accesses that would disturb a running operation are refused and classified. The first such event is latched as a flag with a type code until software reads the status word. A data-ready event and the violation flag each drive the interrupt line through a mask. The cipher engine itself is a stand-in with a subkey phase and a processing phase. Its result is the XOR of input and key, also XORed with the chaining vector in chained mode.

Top module: `cipher_reg_frontend`

## Requirements
- R1: After reset the mode, mask and status words read 0, the interrupt is low, and the version word at 0xFC reads the fix number in bits [18:16] and the version in bits [11:0] (0x000201A5 with default parameters).
- R2: A write to the mode word (0x04) updates bits 0, 2, 3, 7:4, 9:8, 14:12 and 15. The guard bits [29:24] change only when the same write carries 0xE in bits [23:20]. Bits [23:20] always read 0.
- R3: With start field (mode bits [9:8]) at 0, a one-cycle start pulse is issued only by writing bit 0 of the control word (0x00) while the engine is idle. Input writes alone never start it.
- R4: With start field 1, the start pulse follows the write that completes all four input words (0x40..0x4C), and not earlier.
- R5: With start field 2, writing input word 0 starts the engine. If the double-buffer bit (mode bit 3) is set, input writes during a run are accepted, and a word-0 write during a run yields a start as soon as the engine is idle.
- R6: With start field 2 and the double-buffer bit clear, an input write during a run is discarded and recorded as violation type 0.
- R7: Illegal accesses set status bit 8 and type code bits [15:12]: 1 result read while processing, 2 mode write while processing, 3 result read during subkey generation, 4 mode write during subkey generation, 5 read of a write-only word (control, enable, disable, key, input, vector). Such reads return 0 and such mode writes are discarded. The first type is held until a status read (0x1C) clears bit 8 and the type.
- R8: Status bit 0 (data ready) sets when the engine finishes. It clears once each of the four result words (0x50..0x5C) has been read.
- R9: The interrupt equals (status bit 0 AND mask bit 0) OR (status bit 8 AND mask bit 8). Writing 0x10 sets the mask bits written as 1, writing 0x14 clears them, and 0x18 reads the mask.
- R10: Writing bit 8 of the control word returns every register, the banks included, to zero, and the version word is unchanged.
- R11: Writing bit 16 of the control word gives a one-cycle seed pulse and no start pulse.
- R12: Result word i equals input word i XOR key word i, further XORed with vector word i when the operation field (mode bits [14:12]) is 1. The first run after any key write spends a subkey phase before processing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, side effects at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| start_pulse | output | 1 | One-cycle start to the cipher engine |
| seed_pulse | output | 1 | One-cycle seed-load request |
| irq | output | 1 | Masked interrupt |

## Verification
The start logic is exercised under each start field: a manual command after a full block load, an in-order fill of all four words, word 0 written last in single-buffer and double-buffer form, and a swap of the mode during a run. Counting start pulses at a fixed delay after each write separates "started too early", "never started" and "started twice". Violations are provoked in both engine phases, back to back, so that the held type code tells first-wins from last-wins. Result words are compared against values computed from the input, key and vector. One run is in chained mode and one follows a software reset, which shows that the banks were truly cleared.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_MODE  = 8'h04;
  localparam logic [7:0] A_IEN   = 8'h10;
  localparam logic [7:0] A_IDIS  = 8'h14;
  localparam logic [7:0] A_IMASK = 8'h18;
  localparam logic [7:0] A_STAT  = 8'h1C;
  localparam logic [7:0] A_VER   = 8'hFC;

  localparam logic [3:0] B_KEY  = 4'h2;
  localparam logic [3:0] B_DIN  = 4'h4;
  localparam logic [3:0] B_DOUT = 4'h5;
  localparam logic [3:0] B_IV   = 4'h6;

  localparam logic [31:0] MODE_RW   = 32'h0000_F3FD;
  localparam logic [31:0] MODE_PROT = 32'h3F00_0000;
  localparam logic [3:0]  PROT_PASS = 4'hE;

  localparam int CB_GO   = 0;
  localparam int CB_CLR  = 8;
  localparam int CB_SEED = 16;

  localparam logic [2:0] OPM_CHAIN = 3'd1;

  typedef enum logic [1:0] {
    SM_MANUAL = 2'd0,
    SM_FILL   = 2'd1,
    SM_W0     = 2'd2,
    SM_RSVD   = 2'd3
  } smod_e;

  typedef enum logic [3:0] {
    VC_DIN_BUSY  = 4'd0,
    VC_DOUT_BUSY = 4'd1,
    VC_MODE_BUSY = 4'd2,
    VC_DOUT_KEY  = 4'd3,
    VC_MODE_KEY  = 4'd4,
    VC_WO_READ   = 4'd5
  } vcode_e;

  typedef enum logic [1:0] {
    DP_IDLE   = 2'd0,
    DP_KEYGEN = 2'd1,
    DP_PROC   = 2'd2
  } dp_state_e;
endpackage

// File: rtl/crf_cipher_stub.sv
module crf_cipher_stub import crf_pkg::*; #(
  parameter int NWORDS   = 4,
  parameter int KEY_CYC  = 6,
  parameter int PROC_CYC = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    start,
  input  logic                    key_new,
  input  logic [2:0]              op_mode,
  input  logic [NWORDS-1:0][31:0] din,
  input  logic [NWORDS-1:0][31:0] key,
  input  logic [NWORDS-1:0][31:0] chain,
  output logic                    busy,
  output logic                    keygen,
  output logic                    done,
  output logic [NWORDS-1:0][31:0] dout
);
  localparam int CNT_MAX = (KEY_CYC > PROC_CYC) ? KEY_CYC : PROC_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  dp_state_e               st_q, st_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    done_q, done_d;
  logic [NWORDS-1:0][31:0] blk_q, blk_d, res_q, res_d, mix;

  for (genvar w = 0; w < NWORDS; w++) begin : g_mix
    assign mix[w] = din[w] ^ key[w] ^ ((op_mode == OPM_CHAIN) ? chain[w] : 32'h0);
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    blk_d  = blk_q;
    res_d  = res_q;
    done_d = 1'b0;
    unique case (st_q)
      DP_IDLE: if (start) begin
        blk_d = mix;
        if (key_new) begin
          st_d  = DP_KEYGEN;
          cnt_d = CNT_W'(KEY_CYC - 1);
        end else begin
          st_d  = DP_PROC;
          cnt_d = CNT_W'(PROC_CYC - 1);
        end
      end
      DP_KEYGEN: if (cnt_q == '0) begin
        st_d  = DP_PROC;
        cnt_d = CNT_W'(PROC_CYC - 1);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      DP_PROC: if (cnt_q == '0) begin
        st_d   = DP_IDLE;
        done_d = 1'b1;
        res_d  = blk_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      default: st_d = DP_IDLE;
    endcase
    if (clr) begin
      st_d   = DP_IDLE;
      cnt_d  = '0;
      blk_d  = '0;
      res_d  = '0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DP_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      blk_q  <= '0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      blk_q  <= blk_d;
      res_q  <= res_d;
    end
  end

  assign busy   = (st_q != DP_IDLE);
  assign keygen = (st_q == DP_KEYGEN);
  assign done   = done_q;
  assign dout   = res_q;
endmodule

// File: rtl/crf_start_ctrl.sv
module crf_start_ctrl import crf_pkg::*; #(
  parameter int NWORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [1:0]        smod,
  input  logic              go_wr,
  input  logic [NWORDS-1:0] din_wr,
  input  logic              dp_busy,
  output logic              start_pulse
);
  logic              start_q, start_d;
  logic              pend_q, pend_d;
  logic [NWORDS-1:0] fill_q, fill_d;
  logic              busy_any, req_go, req_fill, req_w0, fire;

  assign busy_any = dp_busy | start_q;
  assign req_go   = go_wr && ((smod == SM_MANUAL) || (smod == SM_RSVD));
  assign req_fill = (smod == SM_FILL) && (&(fill_q | din_wr));
  assign req_w0   = (smod == SM_W0) && din_wr[0];
  assign fire     = (req_go || req_fill || req_w0 || pend_q) && !busy_any;

  always_comb begin
    start_d = fire;
    pend_d  = pend_q;
    fill_d  = fill_q | din_wr;
    if (fire) begin
      pend_d = 1'b0;
      fill_d = '0;
    end else if (req_w0) begin
      pend_d = 1'b1;
    end
    if (clr) begin
      start_d = 1'b0;
      pend_d  = 1'b0;
      fill_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      pend_q  <= 1'b0;
      fill_q  <= '0;
    end else begin
      start_q <= start_d;
      pend_q  <= pend_d;
      fill_q  <= fill_d;
    end
  end

  assign start_pulse = start_q;
endmodule

// File: rtl/crf_access_mon.sv
module crf_access_mon import crf_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       sel_mode,
  input  logic       sel_din,
  input  logic       sel_dout,
  input  logic       sel_wo,
  input  logic       strict_w0,
  input  logic       busy_any,
  input  logic       keygen,
  input  logic       stat_rd,
  output logic       viol,
  output logic       urad_q,
  output logic [3:0] urat_q
);
  vcode_e     code;
  logic       urad_d;
  logic [3:0] urat_d;

  always_comb begin
    viol = 1'b1;
    code = VC_WO_READ;
    if (bus_rd && sel_wo)                             code = VC_WO_READ;
    else if (bus_rd && sel_dout && keygen)            code = VC_DOUT_KEY;
    else if (bus_rd && sel_dout && busy_any)          code = VC_DOUT_BUSY;
    else if (bus_wr && sel_mode && keygen)            code = VC_MODE_KEY;
    else if (bus_wr && sel_mode && busy_any)          code = VC_MODE_BUSY;
    else if (bus_wr && sel_din && busy_any && strict_w0) code = VC_DIN_BUSY;
    else                                              viol = 1'b0;
  end

  always_comb begin
    urad_d = urad_q;
    urat_d = urat_q;
    if (stat_rd) begin
      urad_d = 1'b0;
      urat_d = '0;
    end
    if (viol && !urad_q) begin
      urad_d = 1'b1;
      urat_d = code;
    end
    if (clr) begin
      urad_d = 1'b0;
      urat_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urad_q <= 1'b0;
      urat_q <= '0;
    end else begin
      urad_q <= urad_d;
      urat_q <= urat_d;
    end
  end
endmodule

// File: rtl/cipher_reg_frontend.sv
module cipher_reg_frontend import crf_pkg::*; #(
  parameter int          ADDR_W     = 8,
  parameter int          NWORDS     = 4,
  parameter int          KEY_CYC    = 6,
  parameter int          PROC_CYC   = 12,
  parameter logic [11:0] HW_VERSION = 12'h1A5,
  parameter logic [2:0]  HW_FIX     = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              start_pulse,
  output logic              seed_pulse,
  output logic              irq
);
  localparam int IDX_W  = $clog2(NWORDS);
  localparam int BANK_W = ADDR_W - IDX_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // address decode
  logic [IDX_W-1:0]  widx;
  logic [BANK_W-1:0] bank;
  logic sel_ctrl, sel_mode, sel_ien, sel_idis, sel_imask, sel_stat, sel_ver;
  logic sel_key, sel_din, sel_dout, sel_iv, sel_wo;

  assign widx      = bus_addr[IDX_W+1:2];
  assign bank      = bus_addr[ADDR_W-1:IDX_W+2];
  assign sel_ctrl  = (bus_addr == ADDR_W'(A_CTRL));
  assign sel_mode  = (bus_addr == ADDR_W'(A_MODE));
  assign sel_ien   = (bus_addr == ADDR_W'(A_IEN));
  assign sel_idis  = (bus_addr == ADDR_W'(A_IDIS));
  assign sel_imask = (bus_addr == ADDR_W'(A_IMASK));
  assign sel_stat  = (bus_addr == ADDR_W'(A_STAT));
  assign sel_ver   = (bus_addr == ADDR_W'(A_VER));
  assign sel_key   = (bank == BANK_W'(B_KEY));
  assign sel_din   = (bank == BANK_W'(B_DIN));
  assign sel_dout  = (bank == BANK_W'(B_DOUT));
  assign sel_iv    = (bank == BANK_W'(B_IV));
  assign sel_wo    = sel_ctrl | sel_ien | sel_idis | sel_key | sel_din | sel_iv;

  // control pulses
  logic soft_clr, go_wr, seed_q, seed_d;
  assign soft_clr = bus_wr && sel_ctrl && bus_wdata[CB_CLR];
  assign go_wr    = bus_wr && sel_ctrl && bus_wdata[CB_GO];

  // engine status and violation state
  logic       dp_busy, dp_keygen, dp_done, busy_any, keygen_any, viol;
  logic       urad_q, stat_rd, mode_wr_try;
  logic [3:0] urat_q;
  logic       key_dirty_q, key_dirty_d;
  logic [31:0] mode_q, mode_d;
  logic [1:0]  smod;

  assign smod        = mode_q[9:8];
  assign busy_any    = dp_busy | start_pulse;
  assign keygen_any  = dp_keygen | (start_pulse & key_dirty_q);
  assign stat_rd     = bus_rd && sel_stat;
  assign mode_wr_try = bus_wr && sel_mode;

  // word banks
  logic [NWORDS-1:0][31:0] key_q, din_q, iv_q, dout;
  logic [NWORDS-1:0]       key_we, din_we, iv_we, din_ok, dout_hit;

  for (genvar w = 0; w < NWORDS; w++) begin : g_bank
    assign key_we[w]   = bus_wr && sel_key && (widx == IDX_W'(w));
    assign din_we[w]   = bus_wr && sel_din && (widx == IDX_W'(w));
    assign iv_we[w]    = bus_wr && sel_iv  && (widx == IDX_W'(w));
    assign din_ok[w]   = din_we[w] && !viol;
    assign dout_hit[w] = bus_rd && sel_dout && (widx == IDX_W'(w)) && !viol;

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)   key_q[w] <= '0;
      else if (soft_clr) key_q[w] <= '0;
      else if (key_we[w]) key_q[w] <= bus_wdata;
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)   din_q[w] <= '0;
      else if (soft_clr) din_q[w] <= '0;
      else if (din_ok[w]) din_q[w] <= bus_wdata;
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)   iv_q[w] <= '0;
      else if (soft_clr) iv_q[w] <= '0;
      else if (iv_we[w]) iv_q[w] <= bus_wdata;
    end
  end

  // submodules
  crf_start_ctrl #(.NWORDS(NWORDS)) u_start (
    .clk(clk), .rst_n(rst_sync_n), .clr(soft_clr), .smod(smod),
    .go_wr(go_wr), .din_wr(din_ok), .dp_busy(dp_busy),
    .start_pulse(start_pulse)
  );

  crf_access_mon u_mon (
    .clk(clk), .rst_n(rst_sync_n), .clr(soft_clr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .sel_mode(sel_mode), .sel_din(sel_din),
    .sel_dout(sel_dout), .sel_wo(sel_wo),
    .strict_w0((smod == SM_W0) && !mode_q[3]),
    .busy_any(busy_any), .keygen(keygen_any), .stat_rd(stat_rd),
    .viol(viol), .urad_q(urad_q), .urat_q(urat_q)
  );

  crf_cipher_stub #(.NWORDS(NWORDS), .KEY_CYC(KEY_CYC), .PROC_CYC(PROC_CYC)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .clr(soft_clr), .start(start_pulse),
    .key_new(key_dirty_q), .op_mode(mode_q[14:12]),
    .din(din_q), .key(key_q), .chain(iv_q),
    .busy(dp_busy), .keygen(dp_keygen), .done(dp_done), .dout(dout)
  );

  // mode, mask, ready, key tracking: next state
  logic [1:0]        imr_q, imr_d;
  logic              datrdy_q, datrdy_d;
  logic [NWORDS-1:0] rdm_q, rdm_d, rdm_nx;

  assign rdm_nx = rdm_q | dout_hit;

  always_comb begin
    mode_d = mode_q;
    if (mode_wr_try && !viol) begin
      if (bus_wdata[23:20] == PROT_PASS) mode_d = bus_wdata & (MODE_RW | MODE_PROT);
      else                               mode_d = (bus_wdata & MODE_RW) | (mode_q & MODE_PROT);
    end

    imr_d = imr_q;
    if (bus_wr && sel_ien)  imr_d = imr_d | {bus_wdata[8], bus_wdata[0]};
    if (bus_wr && sel_idis) imr_d = imr_d & ~{bus_wdata[8], bus_wdata[0]};

    datrdy_d = datrdy_q;
    rdm_d    = rdm_q;
    if (|dout_hit) begin
      if (&rdm_nx) begin
        datrdy_d = 1'b0;
        rdm_d    = '0;
      end else begin
        rdm_d = rdm_nx;
      end
    end
    if (dp_done) begin
      datrdy_d = 1'b1;
      rdm_d    = '0;
    end

    key_dirty_d = key_dirty_q;
    if (start_pulse) key_dirty_d = 1'b0;
    if (|key_we)     key_dirty_d = 1'b1;

    seed_d = bus_wr && sel_ctrl && bus_wdata[CB_SEED];

    if (soft_clr) begin
      mode_d      = '0;
      imr_d       = '0;
      datrdy_d    = 1'b0;
      rdm_d       = '0;
      key_dirty_d = 1'b0;
      seed_d      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q      <= '0;
      imr_q       <= '0;
      datrdy_q    <= 1'b0;
      rdm_q       <= '0;
      key_dirty_q <= 1'b0;
      seed_q      <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      imr_q       <= imr_d;
      datrdy_q    <= datrdy_d;
      rdm_q       <= rdm_d;
      key_dirty_q <= key_dirty_d;
      seed_q      <= seed_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_rd && !viol) begin
      if (sel_mode)       bus_rdata = mode_q;
      else if (sel_imask) bus_rdata = {23'b0, imr_q[1], 7'b0, imr_q[0]};
      else if (sel_stat)  bus_rdata = {16'b0, urat_q, 3'b0, urad_q, 7'b0, datrdy_q};
      else if (sel_dout)  bus_rdata = dout[widx];
      else if (sel_ver)   bus_rdata = {13'b0, HW_FIX, 4'b0, HW_VERSION};
    end
  end

  assign seed_pulse = seed_q;
  assign irq        = (datrdy_q & imr_q[0]) | (urad_q & imr_q[1]);
endmodule

// File: rtl/crf_checker.sv
module crf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_pulse,
  input logic       dp_busy,
  input logic       dp_done,
  input logic       irq,
  input logic [1:0] imr_q,
  input logic       urad_q,
  input logic [3:0] urat_q,
  input logic       stat_rd,
  input logic       soft_clr,
  input logic       mode_wr,
  input logic [3:0] wr_key,
  input logic [5:0] prot_q,
  input logic       datrdy_q,
  input logic       seed_pulse
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R3

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !dp_busy); // R5

  AST_PROT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && wr_key != 4'hE) |=> $stable(prot_q)); // R2

  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (urad_q && !stat_rd && !soft_clr) |=> (urad_q && $stable(urat_q))); // R7

  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_done && !soft_clr) |=> datrdy_q); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q == 2'b00) |-> !irq); // R9

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!datrdy_q && !urad_q && imr_q == 2'b00 && prot_q == 6'd0)); // R10

  AST_SEED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seed_pulse |=> !seed_pulse); // R11
endmodule

bind cipher_reg_frontend crf_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start_pulse(start_pulse), .dp_busy(dp_busy),
  .dp_done(dp_done), .irq(irq), .imr_q(imr_q), .urad_q(urad_q), .urat_q(urat_q),
  .stat_rd(stat_rd), .soft_clr(soft_clr), .mode_wr(mode_wr_try),
  .wr_key(bus_wdata[23:20]), .prot_q(mode_q[29:24]), .datrdy_q(datrdy_q),
  .seed_pulse(seed_pulse)
);

// File: tb/cipher_reg_frontend_tb.sv
module cipher_reg_frontend_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        start_pulse, seed_pulse, irq;

  int checks = 0;
  int errors = 0;
  int n_start = 0;
  int n_seed = 0;

  logic [31:0] m_key [4];
  logic [31:0] m_din [4];
  logic [31:0] m_iv  [4];
  logic        m_chain = 1'b0;

  always #5 clk = ~clk;

  cipher_reg_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start_pulse(start_pulse),
    .seed_pulse(seed_pulse), .irq(irq)
  );

  always @(posedge clk) begin
    if (start_pulse) n_start <= n_start + 1;
    if (seed_pulse)  n_seed  <= n_seed + 1;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] expect_word(input int i);
    return m_din[i] ^ m_key[i] ^ (m_chain ? m_iv[i] : 32'h0);
  endfunction

  task automatic wait_ready(input string tag);
    logic [31:0] s;
    for (int k = 0; k < 100; k++) begin
      bus_read(8'h1C, s);
      if (s[0]) return;
    end
    chk(tag, 32'h0, 32'h1);
  endtask

  task automatic drain_check(input string tag);
    logic [31:0] d;
    logic [31:0] s;
    for (int i = 0; i < 4; i++) begin
      bus_read(8'h50 + 8'(4 * i), d);
      chk({tag, " result word"}, d, expect_word(i));
      bus_read(8'h1C, s);
      chk({tag, " R8 ready after partial/complete read"}, {31'b0, s[0]}, (i == 3) ? 32'h0 : 32'h1);
    end
  endtask

  task automatic load_din(input logic [31:0] seed, input int first);
    for (int j = 0; j < 4; j++) begin
      int i = (first + 1 + j) % 4;
      m_din[i] = seed ^ (32'h1111_0000 * (i + 1));
      bus_write(8'h40 + 8'(4 * i), m_din[i]);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(8'h04, d); chk("R1 mode after reset", d, 32'h0);
    bus_read(8'h18, d); chk("R1 mask after reset", d, 32'h0);
    bus_read(8'h1C, d); chk("R1 status after reset", d, 32'h0);
    bus_read(8'hFC, d); chk("R1 version word", d, 32'h0002_01A5);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mode_guard();
    logic [31:0] d;
    bus_write(8'h04, 32'h3F50_F3FD);
    bus_read(8'h04, d); chk("R2 guard bits locked by wrong key", d, 32'h0000_F3FD);
    bus_write(8'h04, 32'h3FE0_0001);
    bus_read(8'h04, d); chk("R2 guard bits open with key 0xE", d, 32'h3F00_0001);
    bus_write(8'h04, 32'h0000_0000);
    bus_read(8'h04, d); chk("R2 guard bits kept without key", d, 32'h3F00_0000);
    bus_write(8'h04, 32'h00E0_0000);
    bus_read(8'h04, d); chk("R2 guard bits cleared with key", d, 32'h0);
  endtask

  task automatic t_manual();
    int base;
    for (int i = 0; i < 4; i++) begin
      m_key[i] = 32'hA5A5_0000 + 32'(i * 7);
      m_iv[i]  = 32'h0F0F_0000 + 32'(i * 3);
      bus_write(8'h20 + 8'(4 * i), m_key[i]);
      bus_write(8'h60 + 8'(4 * i), m_iv[i]);
    end
    base = n_start;
    load_din(32'h1234_5678, 3);
    idle(3);
    chk("R3 no start from input writes", 32'(n_start), 32'(base));
    bus_write(8'h00, 32'h1);
    idle(2);
    chk("R3 one start from go bit", 32'(n_start), 32'(base + 1));
    wait_ready("R8 ready after manual run");
    drain_check("R12 manual");
  endtask

  task automatic t_fill();
    int base;
    bus_write(8'h04, 32'h0000_1100);
    m_chain = 1'b1;
    base = n_start;
    for (int i = 0; i < 3; i++) begin
      m_din[i] = 32'hCAFE_0000 + 32'(i);
      bus_write(8'h40 + 8'(4 * i), m_din[i]);
    end
    idle(3);
    chk("R4 no start before last word", 32'(n_start), 32'(base));
    m_din[3] = 32'hCAFE_0003;
    bus_write(8'h4C, m_din[3]);
    idle(2);
    chk("R4 start after fourth word", 32'(n_start), 32'(base + 1));
    wait_ready("R4 ready");
    drain_check("R12 chained");
    m_chain = 1'b0;
  endtask

  task automatic t_word0();
    int base;
    bus_write(8'h04, 32'h0000_0200);
    base = n_start;
    load_din(32'h0BAD_F00D, 0);
    idle(2);
    chk("R5 start on word 0", 32'(n_start), 32'(base + 1));
    wait_ready("R5 ready");
    drain_check("R5 word0");
  endtask

  task automatic t_strict();
    logic [31:0] s;
    load_din(32'h7777_1111, 0);
    bus_write(8'h44, 32'hDEAD_DEAD);
    bus_read(8'h1C, s);
    chk("R6 input write during run flagged type 0", s & 32'hFF00, 32'h0000_0100);
    wait_ready("R6 ready");
    drain_check("R6 discarded write");
  endtask

  task automatic t_dual();
    int base;
    logic [31:0] s;
    bus_write(8'h04, 32'h0000_0208);
    base = n_start;
    load_din(32'h4444_0000, 0);
    load_din(32'h5555_0000, 0);
    bus_read(8'h1C, s);
    chk("R5 double buffer: no violation", s & 32'hFF00, 32'h0);
    chk("R5 second start deferred", 32'(n_start), 32'(base + 1));
    for (int k = 0; k < 60 && n_start < base + 2; k++) idle(1);
    chk("R5 second start after idle", 32'(n_start), 32'(base + 2));
    idle(20);
    drain_check("R5 double buffer");
  endtask

  task automatic t_viol();
    logic [31:0] d;
    logic [31:0] s;
    bus_write(8'h04, 32'h0);
    m_key[0] = 32'h9999_8888;
    bus_write(8'h20, m_key[0]);
    bus_write(8'h00, 32'h1);
    bus_read(8'h50, d);
    chk("R7 result read in subkey phase returns 0", d, 32'h0);
    bus_write(8'h04, 32'h0000_0100);
    bus_read(8'h1C, s);
    chk("R7 first type 3 held over type 4", s & 32'hFF00, 32'h0000_3100);
    bus_read(8'h1C, s);
    chk("R7 status read clears flag", s & 32'hFF00, 32'h0);
    idle(6);
    bus_write(8'h04, 32'h0000_0100);
    bus_read(8'h1C, s);
    chk("R7 mode write while processing type 2", s & 32'hFF00, 32'h0000_2100);
    bus_read(8'h04, d);
    chk("R7 mode write discarded", d, 32'h0);
    bus_read(8'h54, d);
    bus_read(8'h1C, s);
    chk("R7 result read while processing type 1", s & 32'hFF00, 32'h0000_1100);
    wait_ready("R7 ready");
    drain_check("R7 after violations");
    bus_read(8'h20, d);
    chk("R7 write-only read returns 0", d, 32'h0);
    bus_read(8'h1C, s);
    chk("R7 write-only read type 5", s & 32'hFF00, 32'h0000_5100);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(8'h10, 32'h1);
    bus_read(8'h18, d); chk("R9 mask after enable", d, 32'h1);
    bus_write(8'h00, 32'h1);
    wait_ready("R9 ready");
    chk("R9 irq from ready", {31'b0, irq}, 32'h1);
    bus_write(8'h14, 32'h1);
    chk("R9 irq after disable", {31'b0, irq}, 32'h0);
    bus_read(8'h18, d); chk("R9 mask after disable", d, 32'h0);
    bus_write(8'h10, 32'h100);
    chk("R9 irq low without violation", {31'b0, irq}, 32'h0);
    bus_read(8'h14, d);
    chk("R9 irq from violation", {31'b0, irq}, 32'h1);
    bus_read(8'h1C, d);
    chk("R9 irq drops on status read", {31'b0, irq}, 32'h0);
    drain_check("R9 drain");
  endtask

  task automatic t_seed();
    int bs, bst;
    bs = n_seed; bst = n_start;
    bus_write(8'h00, 32'h0001_0000);
    idle(2);
    chk("R11 one seed pulse", 32'(n_seed), 32'(bs + 1));
    chk("R11 no start pulse", 32'(n_start), 32'(bst));
  endtask

  task automatic t_swrst();
    logic [31:0] d;
    bus_write(8'h04, 32'h3FE0_0001);
    bus_write(8'h10, 32'h101);
    bus_write(8'h00, 32'h100);
    bus_read(8'h04, d); chk("R10 mode cleared", d, 32'h0);
    bus_read(8'h18, d); chk("R10 mask cleared", d, 32'h0);
    bus_read(8'h1C, d); chk("R10 status cleared", d, 32'h0);
    bus_read(8'hFC, d); chk("R10 version kept", d, 32'h0002_01A5);
    for (int i = 0; i < 4; i++) begin
      m_key[i] = 32'h0; m_iv[i] = 32'h0; m_din[i] = 32'h0;
    end
    m_din[2] = 32'h600D_0002;
    bus_write(8'h48, m_din[2]);
    bus_write(8'h00, 32'h1);
    wait_ready("R10 ready");
    drain_check("R10 banks cleared");
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    for (int i = 0; i < 4; i++) begin
      m_key[i] = '0; m_din[i] = '0; m_iv[i] = '0;
    end
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_mode_guard();
    t_manual();
    t_fill();
    t_word0();
    t_strict();
    t_dual();
    t_viol();
    t_irq();
    t_seed();
    t_swrst();
    summary();
    $finish;
  end
endmodule